// File: doc/BRIEF.md
# Local Memory Sharing Flag Tracker

This block sits beside the local memory of one processing node in a bus-coupled cluster. It keeps one sharing bit for every cache-block-sized region of that memory. The bit records whether some other node in the cluster has pulled the block into its cache since the node's own cache controller last touched it. The node's own controller presents its accesses on a local port. Coherent traffic from other nodes, seen on the cluster data bus, arrives on a separate remote port.

For each accepted local access the block returns, one cycle later, the sharing bit as it stood before that access. It also returns a routing decision. When the decision is set, the access must also be driven onto the external cluster data bus so that other caches can snoop it. When it is clear, the access can complete entirely inside the node. Most local traffic therefore never occupies the shared bus.

After reset the block walks through the whole flag store, clearing one entry per cycle. While this sweep runs it reports itself busy and ignores both ports.

Top module: `shflag_tracker`

## Requirements
- R1: After reset, `busy` is 1 for at least 2^ADDR_W and at most 2^ADDR_W+4 cycles, then falls and stays 0. Once it has fallen, every block's flag reads 0.
- R2: While `busy` is 1, accesses on either port are ignored. No response is produced and no flag changes.
- R3: A remote access with `rmt_coh`=1 and a data kind sets that block's flag. Data kinds are 01 (read) and 1x (write).
- R4: A local access with `loc_coh`=1 clears that block's flag, whatever its kind, including fetch (00).
- R5: An access with its coherent bit 0 leaves the flag unchanged, whichever port it arrives on.
- R6: A remote access of kind 00 (instruction fetch) leaves the flag unchanged.
- R7: `rsp_valid` is 1 in exactly the cycle after a local strobe accepted while not busy. `rsp_flag` then carries the block's flag as stored before that cycle's updates.
- R8: `rsp_ext` is 1 only with `rsp_valid`, and only when the local access was coherent, of a data kind, and found the flag set. A fetch never routes externally.
- R9: When a local clear and a remote set hit the same block in one cycle, the block ends cleared. When they hit different blocks, both updates take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_vld | input | 1 | Local access strobe |
| loc_addr | input | ADDR_W | Local block address |
| loc_coh | input | 1 | Local access is coherent (1) or non-cacheable (0) |
| loc_kind | input | 2 | Local kind: 00 fetch, 01 read, 1x write |
| rmt_vld | input | 1 | Remote access strobe from the cluster data bus |
| rmt_addr | input | ADDR_W | Remote block address |
| rmt_coh | input | 1 | Remote access is coherent (1) or non-cacheable (0) |
| rmt_kind | input | 2 | Remote kind: 00 fetch, 01 read, 1x write |
| busy | output | 1 | Reset sweep in progress; accesses ignored |
| rsp_valid | output | 1 | Response for the local access of the previous cycle |
| rsp_flag | output | 1 | Sharing flag seen by that access |
| rsp_ext | output | 1 | Access must also go onto the external data bus |

## Verification
The assertions take for granted that the ports are driven with known values whenever the synchronized reset is released. They also rely on the fact that a flag is only read after the sweep has given it a defined value. The stimulus meets these conditions: it drives every input to a defined level from time zero, and it first reads the flag store only once `busy` has fallen. Accesses issued during the sweep deliberately target blocks that are inspected afterwards, so that the ignore rule is observed at the ports. The random phase confines addresses to a handful of blocks, so that same-cycle collisions between the two ports and back-to-back local reads of freshly set blocks occur often.

// File: rtl/shflag_pkg.sv
package shflag_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_READ   = 2'b01,
    KIND_WRITE  = 2'b10,
    KIND_WRITE2 = 2'b11
  } acc_kind_e;

  function automatic logic kind_is_data(input logic [1:0] kind);
    return (kind != KIND_FETCH);
  endfunction
endpackage

// File: rtl/shflag_rst_sync.sv
module shflag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_s = stage2_q;
endmodule

// File: rtl/shflag_sweep.sv
module shflag_sweep #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n_s,
  output logic              busy,
  output logic [ADDR_W-1:0] swp_idx
);
  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy    = busy_q;
  assign swp_idx = idx_q;

  // R1: the sweep cannot end early
  p_sweep_hold_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_q && idx_q != LAST_IDX) |=> busy_q);
  // R1: the sweep ends only after the last entry
  p_sweep_end_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy_q) |-> ($past(idx_q) == LAST_IDX));
  // R1: once done, busy never returns without reset
  p_sweep_once_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/shflag_store.sv
module shflag_store
  import shflag_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n_s,
  input  logic              busy,
  input  logic [ADDR_W-1:0] swp_idx,
  input  logic              loc_vld,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_coh,
  input  logic              rmt_vld,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic              rmt_coh,
  input  logic [1:0]        rmt_kind,
  output logic              rd_flag
);
  localparam int NBLK = 1 << ADDR_W;

  logic [NBLK-1:0] flags;
  logic            loc_acc;
  logic            loc_clr;
  logic            rmt_set;
  logic            rd_q;

  assign loc_acc = loc_vld && !busy;
  assign loc_clr = loc_acc && loc_coh;
  assign rmt_set = rmt_vld && !busy && rmt_coh && kind_is_data(rmt_kind);

  for (genvar gi = 0; gi < NBLK; gi++) begin : g_entry
    logic en_w;
    logic val_w;
    always_comb begin
      en_w  = 1'b0;
      val_w = flags[gi];
      if (busy && swp_idx == ADDR_W'(gi)) begin
        en_w  = 1'b1;
        val_w = 1'b0;
      end else if (loc_clr && loc_addr == ADDR_W'(gi)) begin
        en_w  = 1'b1;
        val_w = 1'b0;
      end else if (rmt_set && rmt_addr == ADDR_W'(gi)) begin
        en_w  = 1'b1;
        val_w = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (en_w) flags[gi] <= val_w;
    end
  end

  always_ff @(posedge clk) begin
    if (loc_acc) rd_q <= flags[loc_addr];
  end

  assign rd_flag = rd_q;

  // R4: a coherent local access leaves its block cleared
  p_local_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    loc_clr |=> !flags[$past(loc_addr)]);
  // R3: a coherent remote data access leaves its block set
  p_remote_set_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rmt_set && !(loc_clr && loc_addr == rmt_addr)) |=> flags[$past(rmt_addr)]);
  // R9: on a same-block collision the clear wins
  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rmt_set && loc_clr && loc_addr == rmt_addr) |=> !flags[$past(loc_addr)]);
  // R5, R6: with no qualifying update the store does not move
  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !loc_clr && !rmt_set) |=> $stable(flags));
endmodule

// File: rtl/shflag_route.sv
module shflag_route
  import shflag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n_s,
  input  logic       busy,
  input  logic       loc_vld,
  input  logic       loc_coh,
  input  logic [1:0] loc_kind,
  input  logic       rd_flag,
  output logic       rsp_valid,
  output logic       rsp_flag,
  output logic       rsp_ext
);
  logic vld_q, vld_d;
  logic qual_q, qual_d;
  logic acc_w;

  assign acc_w = loc_vld && !busy;

  always_comb begin
    vld_d  = acc_w;
    qual_d = qual_q;
    if (acc_w) qual_d = loc_coh && kind_is_data(loc_kind);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q  <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      qual_q <= qual_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_flag  = vld_q && rd_flag;
  assign rsp_ext   = vld_q && qual_q && rd_flag;

  // R7: a response follows only an accepted local strobe
  p_rsp_origin_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(loc_vld && !busy));
  // R2: nothing is answered while sweeping
  p_busy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> !rsp_valid);
  // R8: a fetch never routes to the external bus
  p_fetch_local_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && $past(loc_kind) == KIND_FETCH) |-> !rsp_ext);
  // R8: non-cacheable local accesses never route externally
  p_nc_local_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_valid && !$past(loc_coh)) |-> !rsp_ext);
endmodule

// File: rtl/shflag_tracker.sv
module shflag_tracker #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_vld,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_coh,
  input  logic [1:0]        loc_kind,
  input  logic              rmt_vld,
  input  logic [ADDR_W-1:0] rmt_addr,
  input  logic              rmt_coh,
  input  logic [1:0]        rmt_kind,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_flag,
  output logic              rsp_ext
);
  logic              rst_n_s;
  logic              busy_w;
  logic [ADDR_W-1:0] swp_idx;
  logic              rd_flag;

  shflag_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  shflag_sweep #(.ADDR_W(ADDR_W)) u_sweep (
    .clk     (clk),
    .rst_n_s (rst_n_s),
    .busy    (busy_w),
    .swp_idx (swp_idx)
  );

  shflag_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n_s  (rst_n_s),
    .busy     (busy_w),
    .swp_idx  (swp_idx),
    .loc_vld  (loc_vld),
    .loc_addr (loc_addr),
    .loc_coh  (loc_coh),
    .rmt_vld  (rmt_vld),
    .rmt_addr (rmt_addr),
    .rmt_coh  (rmt_coh),
    .rmt_kind (rmt_kind),
    .rd_flag  (rd_flag)
  );

  shflag_route u_route (
    .clk       (clk),
    .rst_n_s   (rst_n_s),
    .busy      (busy_w),
    .loc_vld   (loc_vld),
    .loc_coh   (loc_coh),
    .loc_kind  (loc_kind),
    .rd_flag   (rd_flag),
    .rsp_valid (rsp_valid),
    .rsp_flag  (rsp_flag),
    .rsp_ext   (rsp_ext)
  );

  assign busy = busy_w;
endmodule

// File: tb/shflag_tracker_bench.sv
module shflag_tracker_bench;
  localparam int ADDR_W = 6;
  localparam int NBLK   = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              loc_vld, loc_coh, rmt_vld, rmt_coh;
  logic [ADDR_W-1:0] loc_addr, rmt_addr;
  logic [1:0]        loc_kind, rmt_kind;
  logic              busy, rsp_valid, rsp_flag, rsp_ext;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;
  bit  mdl [NBLK];

  shflag_tracker #(.ADDR_W(ADDR_W)) u_shflag_tracker (
    .clk(clk), .rst_n(rst_n),
    .loc_vld(loc_vld), .loc_addr(loc_addr), .loc_coh(loc_coh), .loc_kind(loc_kind),
    .rmt_vld(rmt_vld), .rmt_addr(rmt_addr), .rmt_coh(rmt_coh), .rmt_kind(rmt_kind),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_ext(rsp_ext)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the following negedge with outputs compared.
  task automatic step(input logic lv, input int la, input logic lc, input logic [1:0] lk,
                      input logic rv, input int ra, input logic rc, input logic [1:0] rk,
                      input string tag);
    logic acc, ev, ef, ee;
    loc_vld = lv; loc_addr = ADDR_W'(la); loc_coh = lc; loc_kind = lk;
    rmt_vld = rv; rmt_addr = ADDR_W'(ra); rmt_coh = rc; rmt_kind = rk;
    acc = !busy;
    ev = lv && acc;
    ef = ev && mdl[la];
    ee = ef && lc && (lk != 2'b00);
    if (acc) begin
      if (rv && rc && rk != 2'b00) mdl[ra] = 1'b1;
      if (lv && lc) mdl[la] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", rsp_valid, ev);
    if (ev) begin
      check(tag, "rsp_flag", rsp_flag, ef);
      check(tag, "rsp_ext R8", rsp_ext, ee);
    end
    if (acc) check(tag, "busy stays low R1", busy, 1'b0);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 2'b00, 0, 0, 0, 2'b00, tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(1, a, 1, 2'b01, 0, 0, 0, 2'b00, tag);
  endtask

  task automatic rset(input int a, input logic [1:0] k, input logic c, input string tag);
    step(0, 0, 0, 2'b00, 1, a, c, k, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int sweep_len;
    rst_n = 1'b0;
    loc_vld = 0; loc_addr = '0; loc_coh = 0; loc_kind = 2'b00;
    rmt_vld = 0; rmt_addr = '0; rmt_coh = 0; rmt_kind = 2'b00;
    for (int i = 0; i < NBLK; i++) mdl[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 1'b1);
    check("R1", "rsp_valid in reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    // R2: accesses during the sweep, aimed at blocks inspected later
    sweep_len = 0;
    step(0, 0, 0, 2'b00, 1, 5, 1, 2'b01, "R2");
    sweep_len++;
    step(1, 6, 1, 2'b01, 1, 6, 1, 2'b10, "R2");
    sweep_len++;
    while (busy && sweep_len < 1000) begin
      step(1, 5, 1, 2'b01, 1, 5, 1, 2'b01, "R2");
      sweep_len++;
    end
    for (int i = 0; i < NBLK; i++) mdl[i] = 1'b0;
    checks++;
    if (sweep_len < NBLK || sweep_len > NBLK + 4) begin
      failures++;
      $display("FAIL R1 sweep length actual=%0d expected=%0d..%0d", sweep_len, NBLK, NBLK + 4);
    end
    // R1: every flag reads clear after the sweep
    for (int i = 0; i < NBLK; i++) rd(i, "R1");
    // R2: remote activity during sweep left blocks 5 and 6 clear
    rd(5, "R2");
    rd(6, "R2");
    // R3: remote read and remote write each set a flag
    rset(10, 2'b01, 1, "R3");
    rset(11, 2'b11, 1, "R3");
    rd(10, "R3");
    rd(11, "R3");
    // R4: previous coherent reads cleared them
    rd(10, "R4");
    rd(11, "R4");
    // R6: remote fetch does not set
    rset(12, 2'b00, 1, "R6");
    rd(12, "R6");
    // R5: non-cacheable remote access does not set
    rset(13, 2'b01, 0, "R5");
    rd(13, "R5");
    // R5: non-cacheable local access does not clear
    rset(14, 2'b10, 1, "R5");
    step(1, 14, 0, 2'b01, 0, 0, 0, 2'b00, "R5");
    rd(14, "R5");
    // R8: fetch sees flag but stays local, and clears it (R4)
    rset(15, 2'b01, 1, "R8");
    step(1, 15, 1, 2'b00, 0, 0, 0, 2'b00, "R8");
    rd(15, "R4");
    // R8: local write on a shared block routes externally
    rset(16, 2'b01, 1, "R8");
    step(1, 16, 1, 2'b10, 0, 0, 0, 2'b00, "R8");
    // R9: same-block collision, then different blocks
    step(1, 20, 1, 2'b01, 1, 20, 1, 2'b01, "R9");
    rd(20, "R9");
    step(1, 21, 1, 2'b01, 1, 22, 1, 2'b10, "R9");
    rd(22, "R9");
    // R7: back-to-back local reads, with a set just before
    rset(30, 2'b01, 1, "R7");
    rd(30, "R7");
    rd(30, "R7");
    // R7: random mixed traffic over a few blocks
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           1'($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), "R7");
    end
    idle("R7");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule